// File: doc/BRIEF.md
# Line-Locked Spread Spectrum Profile Generator

This block produces the digital modulation profile that steers the fractional feedback of one PLL. The PLL output frequency then sweeps along a repeating triangle. The sweep period is a whole number of output clock cycles. In display use that number is one video line (or a multiple of it), so every line sees the same profile. In standard use it is simply the number of clocks per modulation cycle.

Each clock cycle the block produces two values:

- a signed offset word.
- the effective feedback value, which is the nominal ratio word combined with that offset.

Three inputs set the profile:

- a period count. Its even part is split into a rising half and a falling half of equal length.
- an amplitude word. The peak excursion is the amount by which this word exceeds half the period.
- a nominal ratio word.

A fractional step accumulator spreads the peak over the half-period. The peak is therefore reached exactly at the turning point.

An active-low enable turns spreading on. A synchronous restart input, driven by a line strobe, realigns the profile to its start. Changes to the period, amplitude and ratio take effect only when a new period begins.

Top module: `lineloc_spread_gen`

## Requirements
- R1: While `spread_dis_i` is 1 the block does not spread. After each clock edge at which `spread_dis_i` was 1, `offset_o` is 0 and `fb_eff_o` equals the `ratio_i` value sampled at that edge.
- R2: Let E be `period_i` with bit 0 cleared and H = E/2. The profile index runs 0..E-1 and then wraps to 0. Indices 0..H-1 form the rising half and indices H..E-1 form the falling half.
- R3: Let P = `ampl_i` - H when `ampl_i` > H, else P = 0. At rising index k the magnitude is floor(P*k/H). In the default down-spread shape, `offset_o` = -magnitude.
- R4: At falling index H+j the magnitude is P - floor(P*j/H). Index H therefore carries exactly P.
- R5: `odd_err_o` equals bit 0 of the period value currently in use. An odd period is run as the next lower even count.
- R6: Once enabled, the profile shows index 0 after the first edge. A 1 on `restart_i` at an edge forces index 0 after that edge, with all parameters re-captured.
- R7: `period_i`, `ampl_i` and `ratio_i` are captured only at the edge that starts a period (enable, wrap or restart). Values changed in mid-period have no effect until the next period starts.
- R8: When H is 0 (period below 2), `offset_o` stays 0 and `fb_eff_o` stays equal to the ratio, with parameters captured every cycle.
- R9: In the default shape `fb_eff_o` = ratio - magnitude. It is clamped to 0 when the magnitude exceeds the ratio.
- R10: During reset `offset_o`, `fb_eff_o` and `odd_err_o` are 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock, one profile index per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spread_dis_i | input | 1 | 1 turns spreading off (active-low enable) |
| restart_i | input | 1 | Synchronous realign to profile index 0 |
| period_i | input | NC_W (11) | Clock cycles per modulation period |
| ratio_i | input | MOD_W (13) | Nominal feedback ratio word |
| ampl_i | input | NSS_W (13) | Amplitude word; peak = value minus half-period |
| offset_o | output | NSS_W+1 (14) | Signed per-cycle offset, two's complement |
| fb_eff_o | output | MOD_W+1 (14) | Nominal ratio combined with the offset |
| odd_err_o | output | 1 | Period in use was odd and was rounded down |

## Verification
The bench goes after these corner cases:

- **Turning point.** A design whose accumulator drifted would miss P by one at index H, or carry a remainder into the falling half. The bench checks every index over two full periods for several period and amplitude pairs, including a half-period of one and the largest period.
- **Rounding and small periods.** An odd period must shorten the cycle by one rather than leave a stray index. A period below two must not divide by zero or freeze a non-zero offset.
- **Mid-period writes.** An amplitude or period written in mid-period must not bend the current triangle. A restart must land on index 0 at once.
- **Clamp.** A magnitude larger than the ratio must clamp `fb_eff_o` at 0 rather than wrap it to a large value.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

   // Shape of the offset relative to the nominal ratio
   typedef enum logic [0:0] {
      SHAPE_DOWN   = 1'b0,
      SHAPE_CENTER = 1'b1
   } shape_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ssg_param_latch.sv
// Captures the period, amplitude and ratio words at a period boundary and
// precomputes the peak and the per-cycle step (integer and remainder).
module ssg_param_latch #(
   parameter int NC_W  = 11,
   parameter int MOD_W = 13,
   parameter int NSS_W = 13,
   localparam int HALF_W = NC_W - 1,
   localparam int DW     = ssg_pkg::imax(NSS_W, HALF_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              capture_i,
   input  logic [NC_W-1:0]   period_i,
   input  logic [MOD_W-1:0]  ratio_i,
   input  logic [NSS_W-1:0]  ampl_i,
   output logic [HALF_W-1:0] half_o,
   output logic [NSS_W-1:0]  peak_o,
   output logic [MOD_W-1:0]  ratio_o,
   output logic              odd_o,
   output logic [NSS_W-1:0]  step_q_o,
   output logic [HALF_W-1:0] step_r_o
);

   logic [HALF_W-1:0] half_n;
   logic [DW-1:0]     half_x;
   logic [DW-1:0]     ampl_x;
   logic [DW-1:0]     peak_x;
   logic [DW-1:0]     q_x;
   logic [DW-1:0]     r_x;

   always_comb begin
      half_n = period_i[NC_W-1:1];
      half_x = DW'(half_n);
      ampl_x = DW'(ampl_i);
      peak_x = (ampl_x > half_x) ? (ampl_x - half_x) : '0;
      if (half_x == '0) begin
         q_x = '0;
         r_x = '0;
      end else begin
         q_x = peak_x / half_x;
         r_x = peak_x % half_x;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_o   <= '0;
         peak_o   <= '0;
         ratio_o  <= '0;
         odd_o    <= 1'b0;
         step_q_o <= '0;
         step_r_o <= '0;
      end else if (capture_i) begin
         half_o   <= half_n;
         peak_o   <= NSS_W'(peak_x);
         ratio_o  <= ratio_i;
         odd_o    <= period_i[0];
         step_q_o <= NSS_W'(q_x);
         step_r_o <= HALF_W'(r_x);
      end
   end

endmodule

// File: rtl/ssg_phase_ctr.sv
// Index within the current half-period, direction bit and period-boundary
// detection (enable, wrap, restart, degenerate half of zero).
module ssg_phase_ctr #(
   parameter int HALF_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dis_i,
   input  logic              restart_i,
   input  logic [HALF_W-1:0] half_i,
   output logic              load_o,
   output logic              capture_o,
   output logic              running_o,
   output logic [HALF_W-1:0] idx_o,
   output logic              fall_o,
   output logic              half_end_o
);

   logic last_w;
   logic half_zero_w;
   logic wrap_w;

   always_comb begin
      half_zero_w = (half_i == '0);
      last_w      = (idx_o == (half_i - HALF_W'(1)));
      wrap_w      = running_o & fall_o & last_w & ~half_zero_w;
      load_o      = ~dis_i & (~running_o | restart_i | wrap_w | half_zero_w);
      capture_o   = dis_i | load_o;
      half_end_o  = running_o & last_w & ~half_zero_w;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running_o <= 1'b0;
         idx_o     <= '0;
         fall_o    <= 1'b0;
      end else if (dis_i) begin
         running_o <= 1'b0;
         idx_o     <= '0;
         fall_o    <= 1'b0;
      end else if (load_o) begin
         running_o <= 1'b1;
         idx_o     <= '0;
         fall_o    <= 1'b0;
      end else if (last_w) begin
         idx_o     <= '0;
         fall_o    <= ~fall_o;
      end else begin
         idx_o     <= idx_o + HALF_W'(1);
      end
   end

endmodule

// File: rtl/ssg_frac_acc.sv
// Integer-plus-remainder accumulator: after j steps acc = floor(peak*j/half).
module ssg_frac_acc #(
   parameter int HALF_W = 10,
   parameter int NSS_W  = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              adv_i,
   input  logic [NSS_W-1:0]  step_q_i,
   input  logic [HALF_W-1:0] step_r_i,
   input  logic [HALF_W-1:0] half_i,
   output logic [NSS_W-1:0]  acc_o
);

   logic [HALF_W-1:0] rem_q;
   logic [HALF_W:0]   sum_w;
   logic              carry_w;

   always_comb begin
      sum_w   = {1'b0, rem_q} + {1'b0, step_r_i};
      carry_w = (sum_w >= {1'b0, half_i});
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q <= '0;
         acc_o <= '0;
      end else if (clear_i) begin
         rem_q <= '0;
         acc_o <= '0;
      end else if (adv_i) begin
         rem_q <= carry_w ? HALF_W'(sum_w - {1'b0, half_i}) : HALF_W'(sum_w);
         acc_o <= acc_o + step_q_i + NSS_W'(carry_w);
      end
   end

endmodule

// File: rtl/ssg_shape.sv
// Folds the accumulator into the triangle and forms offset and feedback.
module ssg_shape #(
   parameter int MOD_W = 13,
   parameter int NSS_W = 13,
   parameter ssg_pkg::shape_e SHAPE = ssg_pkg::SHAPE_DOWN,
   localparam int OFS_W = NSS_W + 1,
   localparam int FB_W  = MOD_W + 1,
   localparam int CW    = ssg_pkg::imax(MOD_W, NSS_W) + 2
) (
   input  logic                    running_i,
   input  logic                    fall_i,
   input  logic [NSS_W-1:0]        acc_i,
   input  logic [NSS_W-1:0]        peak_i,
   input  logic [MOD_W-1:0]        ratio_i,
   output logic signed [OFS_W-1:0] offset_o,
   output logic [FB_W-1:0]         fb_o
);

   logic [NSS_W-1:0] mag_w;

   always_comb begin
      if (!running_i)  mag_w = '0;
      else if (fall_i) mag_w = peak_i - acc_i;
      else             mag_w = acc_i;
   end

   if (SHAPE == ssg_pkg::SHAPE_DOWN) begin : g_down
      logic [CW-1:0] r_ext;
      logic [CW-1:0] m_ext;
      always_comb begin
         r_ext    = CW'(ratio_i);
         m_ext    = CW'(mag_w);
         offset_o = -$signed({1'b0, mag_w});
         fb_o     = (r_ext >= m_ext) ? FB_W'(r_ext - m_ext) : '0;
      end
   end else begin : g_center
      logic signed [CW-1:0] ofs_ext;
      logic signed [CW-1:0] sum_ext;
      always_comb begin
         ofs_ext  = running_i ? ($signed(CW'(mag_w)) - $signed(CW'(peak_i >> 1)))
                              : '0;
         sum_ext  = $signed(CW'(ratio_i)) + ofs_ext;
         offset_o = OFS_W'(ofs_ext);
         fb_o     = (sum_ext < 0) ? '0 : FB_W'(sum_ext);
      end
   end

endmodule

// File: rtl/lineloc_spread_gen.sv
module lineloc_spread_gen #(
   parameter int NC_W  = 11,
   parameter int MOD_W = 13,
   parameter int NSS_W = 13,
   parameter ssg_pkg::shape_e SHAPE = ssg_pkg::SHAPE_DOWN,
   localparam int HALF_W = NC_W - 1,
   localparam int OFS_W  = NSS_W + 1,
   localparam int FB_W   = MOD_W + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    spread_dis_i,
   input  logic                    restart_i,
   input  logic [NC_W-1:0]         period_i,
   input  logic [MOD_W-1:0]        ratio_i,
   input  logic [NSS_W-1:0]        ampl_i,
   output logic signed [OFS_W-1:0] offset_o,
   output logic [FB_W-1:0]         fb_eff_o,
   output logic                    odd_err_o
);

   // Elaboration-time parameter checks
   if (NC_W < 3 || NC_W > 16) begin : g_bad_nc_w
      $error("lineloc_spread_gen: NC_W must lie in 3..16");
   end
   if (MOD_W < 2 || MOD_W > 24) begin : g_bad_mod_w
      $error("lineloc_spread_gen: MOD_W must lie in 2..24");
   end
   if (NSS_W < 2 || NSS_W > 24) begin : g_bad_nss_w
      $error("lineloc_spread_gen: NSS_W must lie in 2..24");
   end

   logic              load_w;
   logic              capture_w;
   logic              running_w;
   logic [HALF_W-1:0] idx_w;
   logic              fall_w;
   logic              half_end_w;
   logic [HALF_W-1:0] lat_half_w;
   logic [NSS_W-1:0]  lat_peak_w;
   logic [MOD_W-1:0]  lat_ratio_w;
   logic [NSS_W-1:0]  step_q_w;
   logic [HALF_W-1:0] step_r_w;
   logic [NSS_W-1:0]  acc_w;
   logic              acc_clr_w;

   ssg_param_latch #(
      .NC_W  (NC_W),
      .MOD_W (MOD_W),
      .NSS_W (NSS_W)
   ) u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture_w),
      .period_i  (period_i),
      .ratio_i   (ratio_i),
      .ampl_i    (ampl_i),
      .half_o    (lat_half_w),
      .peak_o    (lat_peak_w),
      .ratio_o   (lat_ratio_w),
      .odd_o     (odd_err_o),
      .step_q_o  (step_q_w),
      .step_r_o  (step_r_w)
   );

   ssg_phase_ctr #(
      .HALF_W (HALF_W)
   ) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dis_i      (spread_dis_i),
      .restart_i  (restart_i),
      .half_i     (lat_half_w),
      .load_o     (load_w),
      .capture_o  (capture_w),
      .running_o  (running_w),
      .idx_o      (idx_w),
      .fall_o     (fall_w),
      .half_end_o (half_end_w)
   );

   assign acc_clr_w = spread_dis_i | load_w | half_end_w;

   ssg_frac_acc #(
      .HALF_W (HALF_W),
      .NSS_W  (NSS_W)
   ) u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (acc_clr_w),
      .adv_i    (running_w),
      .step_q_i (step_q_w),
      .step_r_i (step_r_w),
      .half_i   (lat_half_w),
      .acc_o    (acc_w)
   );

   ssg_shape #(
      .MOD_W (MOD_W),
      .NSS_W (NSS_W),
      .SHAPE (SHAPE)
   ) u_shape (
      .running_i (running_w),
      .fall_i    (fall_w),
      .acc_i     (acc_w),
      .peak_i    (lat_peak_w),
      .ratio_i   (lat_ratio_w),
      .offset_o  (offset_o),
      .fb_o      (fb_eff_o)
   );

endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
   parameter int MOD_W  = 13,
   parameter int NSS_W  = 13,
   parameter int HALF_W = 10,
   parameter ssg_pkg::shape_e SHAPE = ssg_pkg::SHAPE_DOWN,
   localparam int OFS_W = NSS_W + 1,
   localparam int FB_W  = MOD_W + 1
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    spread_dis_i,
   input logic                    period_lsb_i,
   input logic [MOD_W-1:0]        ratio_i,
   input logic signed [OFS_W-1:0] offset_o,
   input logic [FB_W-1:0]         fb_eff_o,
   input logic                    odd_err_o,
   input logic                    load_i,
   input logic                    running_i,
   input logic [HALF_W-1:0]       idx_i,
   input logic                    fall_i,
   input logic [HALF_W-1:0]       half_i,
   input logic [NSS_W-1:0]        peak_i,
   input logic [NSS_W-1:0]        acc_i
);

   assert_idle_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(spread_dis_i)) |->
         (offset_o == '0 && fb_eff_o == FB_W'($past(ratio_i))));

   assert_equal_halves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(running_i) && !$past(load_i) && !$past(spread_dis_i)
       && (fall_i != $past(fall_i))) |->
         ($past(idx_i + HALF_W'(1)) == $past(half_i)));

   assert_within_peak_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      running_i |-> (acc_i <= peak_i));

   assert_odd_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && ($past(load_i) || $past(spread_dis_i))) |->
         (odd_err_o == $past(period_lsb_i)));

   assert_hold_params_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(load_i) && !$past(spread_dis_i)) |->
         ($stable(peak_i) && $stable(half_i)));

   if (SHAPE == ssg_pkg::SHAPE_DOWN) begin : g_down_chk
      assert_down_sign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         running_i |-> (offset_o <= 0));
   end

endmodule

bind lineloc_spread_gen ssg_checker #(
   .MOD_W  (MOD_W),
   .NSS_W  (NSS_W),
   .HALF_W (HALF_W),
   .SHAPE  (SHAPE)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .spread_dis_i (spread_dis_i),
   .period_lsb_i (period_i[0]),
   .ratio_i      (ratio_i),
   .offset_o     (offset_o),
   .fb_eff_o     (fb_eff_o),
   .odd_err_o    (odd_err_o),
   .load_i       (load_w),
   .running_i    (running_w),
   .idx_i        (idx_w),
   .fall_i       (fall_w),
   .half_i       (lat_half_w),
   .peak_i       (lat_peak_w),
   .acc_i        (acc_w)
);

// File: tb/lineloc_spread_gen_tb_top.sv
module lineloc_spread_gen_tb_top;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               dis = 1'b1;
   logic               rst_req = 1'b0;
   logic [10:0]        period = '0;
   logic [12:0]        ratio = '0;
   logic [12:0]        ampl = '0;
   logic signed [13:0] offset;
   logic [13:0]        fb;
   logic               oddf;

   always #4 clk = ~clk;   // 125 MHz

   lineloc_spread_gen dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .spread_dis_i (dis),
      .restart_i    (rst_req),
      .period_i     (period),
      .ratio_i      (ratio),
      .ampl_i       (ampl),
      .offset_o     (offset),
      .fb_eff_o     (fb),
      .odd_err_o    (oddf)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int grp_bad, grp_act, grp_exp;

   // {period, amplitude, ratio}
   localparam int NVEC = 8;
   localparam int VEC [NVEC][3] = '{
      '{20,   14,   1000},
      '{21,   20,   500},
      '{8,    100,  50},
      '{640,  321,  160},
      '{6,    2,    300},
      '{1620, 814,  400},
      '{2,    9,    100},
      '{2047, 2047, 8191}
   };

   function automatic int exp_mag(int nc, int nss, int k);
      int ne = nc & ~1;
      int h  = ne / 2;
      int p, kk;
      if (h == 0) return 0;
      p  = (nss > h) ? nss - h : 0;
      kk = k % ne;
      if (kk < h) return (p * kk) / h;
      return p - (p * (kk - h)) / h;
   endfunction

   function automatic int exp_fb(int r, int m);
      return (r >= m) ? r - m : 0;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic grp_start();
      grp_bad = 0; grp_act = 0; grp_exp = 0;
   endtask

   // sample one index at the negative edge
   task automatic step_cmp(int nc, int nss, int r, int k);
      int m;
      @(negedge clk);
      m = exp_mag(nc, nss, k);
      if (int'(offset) != -m || int'(fb) != exp_fb(r, m)) begin
         if (grp_bad == 0) begin
            grp_act = (int'(offset) != -m) ? int'(offset) : int'(fb);
            grp_exp = (int'(offset) != -m) ? -m : exp_fb(r, m);
         end
         grp_bad++;
      end
   endtask

   task automatic grp_end(string req);
      chk(grp_bad == 0, req, grp_act, grp_exp);
   endtask

   task automatic program_and_enable(int nc, int nss, int r);
      @(negedge clk);
      dis = 1'b1; period = 11'(nc); ampl = 13'(nss); ratio = 13'(r);
      @(negedge clk);
      dis = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R10: reset state with non-zero inputs
      ratio = 13'd99; ampl = 13'd50; period = 11'd21; dis = 1'b0;
      repeat (3) @(negedge clk);
      chk(offset == 0, "R10 offset in reset", int'(offset), 0);
      chk(fb == 0, "R10 fb in reset", int'(fb), 0);
      chk(oddf == 1'b0, "R10 odd flag in reset", int'(oddf), 0);
      dis = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;

      // R1: disabled passthrough of the ratio
      @(negedge clk); ratio = 13'd1234;
      @(negedge clk);
      chk(fb == 14'd1234, "R1 fb follows ratio", int'(fb), 1234);
      chk(offset == 0, "R1 offset zero when off", int'(offset), 0);
      ratio = 13'd4321;
      @(negedge clk);
      chk(fb == 14'd4321, "R1 fb follows new ratio", int'(fb), 4321);

      // Vector table: R2 R3 R4 R9, two full periods each
      for (int v = 0; v < NVEC; v++) begin
         int ne;
         program_and_enable(VEC[v][0], VEC[v][1], VEC[v][2]);
         ne = VEC[v][0] & ~1;
         grp_start();
         for (int k = 0; k < 2 * ne; k++) step_cmp(VEC[v][0], VEC[v][1], VEC[v][2], k);
         grp_end($sformatf("R2 R3 R4 R9 vector %0d", v));
         chk(oddf == VEC[v][0][0], $sformatf("R5 odd flag vector %0d", v),
             int'(oddf), VEC[v][0] & 1);
      end

      // R6: restart in mid-rise realigns to index 0
      program_and_enable(20, 14, 1000);
      for (int k = 0; k < 8; k++) @(negedge clk);   // now at index 7
      rst_req = 1'b1;
      grp_start();
      step_cmp(20, 14, 1000, 0);
      rst_req = 1'b0;
      for (int k = 1; k < 25; k++) step_cmp(20, 14, 1000, k);
      grp_end("R6 restart realign");

      // R7: mid-period change takes effect only at the wrap
      program_and_enable(20, 20, 700);
      grp_start();
      for (int k = 0; k < 6; k++) step_cmp(20, 20, 700, k);
      period = 11'd40; ampl = 13'd40; ratio = 13'd900;
      for (int k = 6; k < 20; k++) step_cmp(20, 20, 700, k);
      grp_end("R7 old period kept");
      grp_start();
      for (int k = 0; k < 40; k++) step_cmp(40, 40, 900, k);
      grp_end("R7 new period applied at wrap");

      // Disable in mid-run returns to nominal at once (R1)
      program_and_enable(20, 20, 700);
      for (int k = 0; k < 5; k++) @(negedge clk);
      chk(offset == -14'sd4, "R3 index 4 before disable", int'(offset), -4);
      dis = 1'b1;
      @(negedge clk);
      chk(offset == 0, "R1 offset zero after disable", int'(offset), 0);
      chk(fb == 14'd700, "R1 fb nominal after disable", int'(fb), 700);

      // R8: periods of 1 and 0 never spread
      program_and_enable(1, 50, 77);
      grp_start();
      for (int k = 0; k < 10; k++) step_cmp(1, 50, 77, k);
      grp_end("R8 period one");
      chk(oddf == 1'b1, "R5 odd flag period one", int'(oddf), 1);
      program_and_enable(0, 50, 88);
      grp_start();
      for (int k = 0; k < 10; k++) step_cmp(0, 50, 88, k);
      grp_end("R8 period zero");
      chk(oddf == 1'b0, "R5 odd flag period zero", int'(oddf), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule